// File: doc/BRIEF.md
# Byte-to-Word Flash Write Sequencer

This block sits between a DMA engine and a 32-bit flash word programmer. Software programs a block length in bytes and then sets the WRITE control bit. From that point the sequencer raises a single-transfer request whenever its data register can take another byte. The DMA answers each request by writing one byte to a fixed data address. Every four bytes are packed into one word, which goes out on a valid/ready port to the programmer.

The write ends in one of two ways. In the normal case, WRITE drops once the last full word has been handed over. Trailing bytes of a length that is not a multiple of four are taken in and then thrown away. In the other case the data stream stalls. If a request stays unanswered for a programmable number of cycles (20 µs at the clock rate), the write is abandoned, WRITE is cleared and a sticky timeout flag is raised. The request identifier that the DMA uses for this source is presented as a constant output.

Top module: `flash_byte_seq`

## Requirements
- R1: The register port has four addresses. Address 0 is control: writing a 1 in bit 0 starts a block write, but only while WRITE is clear; such a write during a block write has no effect. Address 1 holds the low byte of the block length and address 2 holds the high byte; the length is copied when the write starts. Address 3 is the data register.
- R2: `dma_req` is high exactly when WRITE is set, no packed word is waiting for the programmer, and bytes remain in the block. It first goes high in the cycle after the start write.
- R3: A write to the data register is accepted only in a cycle where `dma_req` is high. At any other time it is ignored, and it neither changes the packed words nor counts against the length.
- R4: Bytes are packed little-endian: the first byte of each group of four lands in bits 7:0 and the fourth in bits 31:24. `word_valid` rises on the edge that takes the fourth byte. It then holds, with `word_data` stable, until the cycle in which `word_ready` is high.
- R5: If the length is not a multiple of 4, the remaining 1 to 3 bytes are accepted but never presented. WRITE clears on the edge after the last byte, or after the last word is handed over if that happens later.
- R6: When the length is a multiple of 4, WRITE clears on the same edge as the handshake of the final word. A length of 0 clears WRITE one cycle after the start, and no request is ever made.
- R7: The timeout counter advances only while `dma_req` is high. If `dma_req` stays high for TIMEOUT_CYC cycles in a row with no byte taken, WRITE clears and `timeout_flag` sets on that edge, and the partial word is dropped. While a word is held for the programmer, the counter does not advance.
- R8: A byte that arrives in the last waiting cycle before expiry is accepted. It restarts the count, and the write goes on.
- R9: `timeout_flag` stays set until the next start of a block write, which clears it.
- R10: `dma_trig_id` always reads 18 (binary 10010).
- R11: After reset, WRITE, `dma_req`, `word_valid` and `timeout_flag` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address (0 control, 1 length low, 2 length high, 3 data) |
| reg_wdata | input | 8 | Register write data |
| dma_req | output | 1 | Single-byte transfer request to the DMA |
| dma_trig_id | output | 5 | Constant trigger number of this request source |
| word_data | output | 32 | Packed word for the flash programmer |
| word_valid | output | 1 | Packed word is valid |
| word_ready | input | 1 | Programmer takes the word |
| write_busy | output | 1 | WRITE control bit |
| timeout_flag | output | 1 | Sticky flag for a write abandoned on timeout |

## Verification
Two events can land in the same cycle: a byte arriving and the starvation counter expiring. The bench provokes this by holding the data write back until the exact last waiting cycle, then checks that the byte wins, WRITE stays set and the block finishes. A second coincidence is the handshake of the final word on the edge that clears WRITE. This is judged with the programmer both ready at once and stalled well past the timeout, since a stall must not count toward it. A cycle-accurate behavioural model compares requests, WRITE, the flag and the word port on every clock.

// File: rtl/flash_byte_seq_pkg.sv
package flash_byte_seq_pkg;
    localparam int REG_AW = 2;
    localparam logic [REG_AW-1:0] ADDR_CTRL   = 2'd0;
    localparam logic [REG_AW-1:0] ADDR_LEN_LO = 2'd1;
    localparam logic [REG_AW-1:0] ADDR_LEN_HI = 2'd2;
    localparam logic [REG_AW-1:0] ADDR_DATA   = 2'd3;
    localparam logic [4:0]        SRC_TRIG_ID = 5'b10010;
endpackage

// File: rtl/fbs_packer.sv
module fbs_packer #(
    parameter int BYTES = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 clear,
    input  logic                 in_vld,
    input  logic [7:0]           in_byte,
    input  logic                 out_ready,
    output logic [BYTES*8-1:0]   out_word,
    output logic                 out_vld
);
    localparam int WORD_W = BYTES * 8;
    localparam int IDX_W  = (BYTES > 1) ? $clog2(BYTES) : 1;
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(BYTES - 1);

    typedef struct packed {
        logic [IDX_W-1:0]  idx;
        logic [WORD_W-1:0] part;
        logic [WORD_W-1:0] word;
        logic              vld;
    } pk_t;

    pk_t st_q, st_d;

    always_comb begin
        st_d = st_q;
        if (st_q.vld && out_ready)
            st_d.vld = 1'b0;
        if (clear) begin
            st_d.idx = '0;
        end else if (in_vld) begin
            st_d.part[st_q.idx*8 +: 8] = in_byte;
            if (st_q.idx == LAST_IDX) begin
                st_d.word = st_d.part;
                st_d.vld  = 1'b1;
                st_d.idx  = '0;
            end else begin
                st_d.idx = st_q.idx + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign out_word = st_q.word;
    assign out_vld  = st_q.vld;

    p_word_held_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (out_vld && !out_ready) |=> (out_vld && $stable(out_word)));
endmodule

// File: rtl/fbs_starve_timer.sv
module fbs_starve_timer #(
    parameter int TIMEOUT_CYC = 4000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic restart,
    input  logic waiting,
    output logic expired
);
    localparam int CNT_W = $clog2(TIMEOUT_CYC + 1);
    localparam logic [CNT_W-1:0] LOAD = CNT_W'(TIMEOUT_CYC);

    logic [CNT_W-1:0] cnt_q, cnt_d;

    always_comb begin
        cnt_d = cnt_q;
        if (restart)
            cnt_d = LOAD;
        else if (waiting && cnt_q != '0)
            cnt_d = cnt_q - 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= LOAD;
        else        cnt_q <= cnt_d;
    end

    assign expired = waiting && !restart && (cnt_q == CNT_W'(1));

    p_idle_keeps_count_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!waiting && !restart) |=> $stable(cnt_q));
endmodule

// File: rtl/flash_byte_seq.sv
module flash_byte_seq
    import flash_byte_seq_pkg::*;
#(
    parameter int LEN_W       = 16,
    parameter int TIMEOUT_CYC = 4000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr_en,
    input  logic [REG_AW-1:0] reg_addr,
    input  logic [7:0]        reg_wdata,
    output logic              dma_req,
    output logic [4:0]        dma_trig_id,
    output logic [31:0]       word_data,
    output logic              word_valid,
    input  logic              word_ready,
    output logic              write_busy,
    output logic              timeout_flag
);
    localparam int BYTES_PER_WORD = 4;

    typedef struct packed {
        logic             wr;
        logic             flag;
        logic [LEN_W-1:0] len;
        logic [LEN_W-1:0] left;
    } ctl_t;

    ctl_t st_q, st_d;
    logic start, byte_acc, finish, abort, expired, pk_clear;

    always_comb begin
        dma_req  = st_q.wr && !word_valid && (st_q.left != '0);
        start    = reg_wr_en && (reg_addr == ADDR_CTRL) && reg_wdata[0] && !st_q.wr;
        byte_acc = dma_req && reg_wr_en && (reg_addr == ADDR_DATA);
        finish   = st_q.wr && (st_q.left == '0) && (!word_valid || word_ready);
        abort    = expired && !byte_acc;
        pk_clear = start || finish || abort;

        st_d = st_q;
        if (reg_wr_en && reg_addr == ADDR_LEN_LO)
            st_d.len[7:0] = reg_wdata;
        if (reg_wr_en && reg_addr == ADDR_LEN_HI)
            st_d.len[LEN_W-1:8] = reg_wdata[LEN_W-9:0];
        if (start) begin
            st_d.wr   = 1'b1;
            st_d.flag = 1'b0;
            st_d.left = st_q.len;
        end else if (byte_acc) begin
            st_d.left = st_q.left - 1'b1;
        end else if (abort) begin
            st_d.wr   = 1'b0;
            st_d.flag = 1'b1;
        end else if (finish) begin
            st_d.wr = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    fbs_packer #(.BYTES(BYTES_PER_WORD)) u_packer (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear     (pk_clear),
        .in_vld    (byte_acc),
        .in_byte   (reg_wdata),
        .out_ready (word_ready),
        .out_word  (word_data),
        .out_vld   (word_valid)
    );

    fbs_starve_timer #(.TIMEOUT_CYC(TIMEOUT_CYC)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (start || byte_acc),
        .waiting (dma_req),
        .expired (expired)
    );

    assign dma_trig_id  = SRC_TRIG_ID;
    assign write_busy   = st_q.wr;
    assign timeout_flag = st_q.flag;

    p_first_req_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (start && st_q.len != '0) |=> dma_req);
    p_req_only_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
        dma_req |-> (write_busy && !word_valid));
    p_abort_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
        abort |=> (!write_busy && timeout_flag));
    p_flag_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (timeout_flag && !start) |=> timeout_flag);
    p_busy_ignores_start_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (write_busy && !byte_acc && !finish && !abort) |=> ($stable(st_q.left) && write_busy));
endmodule

// File: tb/flash_byte_seq_tb.sv
`timescale 1ns/1ps
module flash_byte_seq_tb;
    localparam int TO = 12;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr_en = 1'b0;
    logic [1:0]  reg_addr = '0;
    logic [7:0]  reg_wdata = '0;
    logic        word_ready = 1'b1;
    logic        dma_req, word_valid, write_busy, timeout_flag;
    logic [4:0]  dma_trig_id;
    logic [31:0] word_data;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    flash_byte_seq #(.LEN_W(16), .TIMEOUT_CYC(TO)) u_dut (
        .clk(clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .dma_req(dma_req), .dma_trig_id(dma_trig_id),
        .word_data(word_data), .word_valid(word_valid), .word_ready(word_ready),
        .write_busy(write_busy), .timeout_flag(timeout_flag)
    );

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    // behavioural reference model
    bit          m_w, m_flag, m_pend;
    int          m_len, m_left, m_nb, m_idle;
    logic [7:0]  m_bytes[$];
    logic [31:0] m_word;
    logic [31:0] got[$];

    always @(posedge clk) begin
        bit req, acc, w, fl, pd;
        int lf, nb, idl;
        logic [31:0] wd;
        if (!rst_n) begin
            m_w = 0; m_flag = 0; m_pend = 0; m_len = 0; m_left = 0; m_nb = 0; m_idle = 0;
            m_bytes.delete();
        end else begin
            if (m_pend && word_ready) got.push_back(m_word);
            req = m_w && !m_pend && m_left != 0;
            acc = req && reg_wr_en && reg_addr == 2'd3;
            w = m_w; fl = m_flag; pd = m_pend; lf = m_left; nb = m_nb; idl = m_idle; wd = m_word;
            if (m_pend && word_ready) pd = 0;
            if (!m_w) begin
                if (reg_wr_en && reg_addr == 2'd0 && reg_wdata[0]) begin
                    w = 1; fl = 0; idl = 0; lf = m_len; m_bytes.delete(); nb = 0;
                end
            end else if (acc) begin
                m_bytes.push_back(reg_wdata);
                nb = m_nb + 1; lf = m_left - 1; idl = 0;
                if (nb == 4) begin
                    wd = {m_bytes[3], m_bytes[2], m_bytes[1], m_bytes[0]};
                    m_bytes.delete(); pd = 1; nb = 0;
                end
            end else if (req && m_idle + 1 == TO) begin
                w = 0; fl = 1; nb = 0; m_bytes.delete();
            end else if (req) begin
                idl = m_idle + 1;
            end else if (m_left == 0 && (!m_pend || word_ready)) begin
                w = 0; nb = 0; m_bytes.delete();
            end
            if (reg_wr_en && reg_addr == 2'd1) m_len = (m_len & 16'hFF00) | int'(reg_wdata);
            if (reg_wr_en && reg_addr == 2'd2) m_len = (m_len & 16'h00FF) | (int'(reg_wdata) << 8);
            m_w = w; m_flag = fl; m_pend = pd; m_left = lf; m_nb = nb; m_idle = idl; m_word = wd;
        end
    end

    always @(negedge clk) begin
        if (rst_n && !finished) begin
            check(dma_req == (m_w && !m_pend && m_left != 0), "R2 req", dma_req, m_w && !m_pend && m_left != 0);
            check(write_busy == m_w, "R6/R7 write", write_busy, m_w);
            check(timeout_flag == m_flag, "R9 flag", timeout_flag, m_flag);
            check(word_valid == m_pend, "R4 valid", word_valid, m_pend);
            if (m_pend) check(word_data == m_word, "R4 data", word_data, m_word);
        end
    end

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk); reg_wr_en = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk); reg_wr_en = 1'b0;
    endtask

    task automatic begin_block(input int len);
        wr(2'd1, len[7:0]);
        wr(2'd2, len[15:8]);
        wr(2'd0, 8'h01);
    endtask

    task automatic push(input logic [7:0] d);
        int guard = 0;
        @(negedge clk);
        while (!dma_req && guard < 200) begin @(negedge clk); guard++; end
        reg_wr_en = 1'b1; reg_addr = 2'd3; reg_wdata = d;
        @(negedge clk); reg_wr_en = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        #(200000 * 5);
        check(1'b0, "watchdog", 0, 1);
        finished = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check(!write_busy && !dma_req && !word_valid && !timeout_flag, "R11 reset", {write_busy, dma_req, word_valid, timeout_flag}, 0);
        check(dma_trig_id == 5'd18, "R10 trig id", dma_trig_id, 18);
        rst_n = 1'b1;

        // R1 R2 R4 R6: 8 bytes, ready held high
        got.delete();
        begin_block(8);
        check(dma_req == 1'b1, "R2 first req", dma_req, 1);
        for (int i = 0; i < 8; i++) begin push(8'h10 + 8'(i)); idle(i % 3); end
        idle(4);
        check(got.size() == 2, "R6 word count", got.size(), 2);
        if (got.size() == 2) begin
            check(got[0] == 32'h13121110, "R4 little endian", got[0], 32'h13121110);
            check(got[1] == 32'h17161514, "R4 second word", got[1], 32'h17161514);
        end
        check(!write_busy, "R6 done", write_busy, 0);

        // R3 R1 R7: word held longer than timeout, stray data and start ignored
        got.delete();
        word_ready = 1'b0;
        begin_block(4);
        for (int i = 0; i < 4; i++) push(8'hA0 + 8'(i));
        wr(2'd3, 8'h55);
        wr(2'd0, 8'h01);
        idle(TO + 5);
        check(write_busy && word_valid && !timeout_flag, "R7 paused while held", {write_busy, word_valid, timeout_flag}, 3'b110);
        @(negedge clk); word_ready = 1'b1;
        idle(3);
        check(got.size() == 1 && got[0] == 32'hA3A2A1A0, "R3 stray byte ignored", got.size() ? got[0] : 0, 32'hA3A2A1A0);
        check(!write_busy, "R1 busy start ignored", write_busy, 0);

        // R5: length 6, trailing two bytes dropped
        got.delete();
        begin_block(6);
        for (int i = 0; i < 6; i++) push(8'hC0 + 8'(i));
        idle(3);
        check(got.size() == 1, "R5 partial discarded", got.size(), 1);
        check(!write_busy && !word_valid, "R5 write cleared", {write_busy, word_valid}, 0);

        // R6 length zero
        begin_block(0);
        idle(2);
        check(!write_busy && !dma_req, "R6 zero length", {write_busy, dma_req}, 0);

        // R7 timeout and R9 sticky
        got.delete();
        begin_block(8);
        push(8'h01); push(8'h02);
        idle(TO + 3);
        check(!write_busy && timeout_flag, "R7 timeout abort", {write_busy, timeout_flag}, 2'b01);
        idle(5);
        check(timeout_flag, "R9 flag sticky", timeout_flag, 1);
        check(got.size() == 0, "R7 partial dropped", got.size(), 0);

        // R8 byte on the last waiting cycle; R9 cleared by start
        begin_block(4);
        check(!timeout_flag, "R9 cleared on start", timeout_flag, 0);
        push(8'hE0);
        idle(TO - 1);
        reg_wr_en = 1'b1; reg_addr = 2'd3; reg_wdata = 8'hE1;
        @(negedge clk); reg_wr_en = 1'b0;
        check(write_busy && !timeout_flag, "R8 byte wins", {write_busy, timeout_flag}, 2'b10);
        push(8'hE2); push(8'hE3);
        idle(3);
        check(got.size() == 1 && got[0] == 32'hE3E2E1E0, "R8 word after race", got.size() ? got[0] : 0, 32'hE3E2E1E0);

        idle(2);
        finished = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule